// File: doc/BRIEF.md
# Modem Transmit Serializer with Header and Frame Checks

This block carries a transmit frame from the host into a serial bit stream for the baseband. The host hands over one byte at a time through a ready/valid handshake in the system clock domain. No FIFO sits in the path: a byte is held until the transmit clock domain takes it. Each byte can carry a header-end marker and a last-byte marker. The serializer works on the transmit clock that the baseband supplies. It sends the header bytes, then a 16-bit header check, then the payload bytes, then a 32-bit frame check. Both checks are computed bit by bit as the data goes out.

A frame begins when the first byte is pending and the synchronized clear-channel input reports a free medium. While the medium is busy the block waits, and the transmit-ready output stays low. The host must keep bytes flowing. If the shifter finishes a byte and the next one has not arrived, the block ends the frame early and sets a sticky underrun flag.

The transmit-domain state machine has six states:
- ST_IDLE: no frame in progress.
- ST_WAIT_CLR: a byte is pending but the channel is busy.
- ST_HDR: sending header bytes.
- ST_HEC: sending the header check.
- ST_PAY: sending payload bytes.
- ST_FCS: sending the frame check.

Its transitions are:
- start: ST_IDLE or ST_WAIT_CLR to ST_HDR.
- defer: ST_IDLE to ST_WAIT_CLR.
- header-done: ST_HDR to ST_HEC.
- payload-start: ST_HEC to ST_PAY.
- payload-done: ST_PAY to ST_FCS.
- frame-end: ST_FCS to ST_IDLE.
- underrun: ST_HDR, ST_HEC or ST_PAY to ST_IDLE.

Top module: `modem_tx_serializer`

## Requirements
- R1: After reset, tx_rdy=0, txd=0, underrun=0 and in_ready=1.
- R2: A byte is accepted when in_valid and in_ready are both high at a rising sys_clk edge. in_ready then goes low, and it returns only after the serializer has taken that byte, so at most one byte is outstanding.
- R3: While a byte is pending and chan_clear=0, tx_rdy stays 0. The frame starts only after chan_clear=1 has passed the synchronizer.
- R4: Once a frame has started, chan_clear has no effect on the bit stream.
- R5: tx_rdy is high for exactly 8*(header bytes + payload bytes) + 48 tx_clk cycles per frame, one bit per cycle on txd (updated on the rising tx_clk edge). txd is 0 whenever tx_rdy is 0.
- R6: Bytes are sent least significant bit first. Header bytes are sent in order, up to and including the byte with in_hend=1.
- R7: Right after the header come 16 check bits. The register starts at 0xFFFF. For each header bit b in send order it updates as c = (c<<1) ^ (0x1021 if b^c[15]). The complement ~c is sent bit 15 first.
- R8: Payload bytes follow the header check, up to and including the byte with in_last=1. in_last is ignored on header bytes.
- R9: After the last payload byte come 32 check bits. The register starts at 0xFFFFFFFF. For each payload bit b it updates as c = (c>>1) ^ (0xEDB88320 if b^c[0]). The complement ~c is sent bit 0 first. For payload ASCII "123456789" the sent value is 0xCBF43926.
- R10: If a byte boundary needs a new byte and none is pending, tx_rdy falls after the last bit of the current byte and underrun goes to 1. underrun stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Host-side clock |
| sys_rst_n | input | 1 | Active-low reset, host domain |
| in_valid | input | 1 | Host presents a byte |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | BYTE_W | Byte to send |
| in_hend | input | 1 | Byte is the final header byte |
| in_last | input | 1 | Byte is the final payload byte |
| tx_clk | input | 1 | Transmit bit clock from the baseband |
| tx_rst_n | input | 1 | Active-low reset, transmit domain |
| chan_clear | input | 1 | 1 when the medium is free |
| txd | output | 1 | Serial data |
| tx_rdy | output | 1 | Serial data is being presented |
| underrun | output | 1 | Sticky byte-starvation flag |

## Verification
The bench builds the block with its defaults: 8-bit bytes and two synchronizer stages. The transmit clock runs four times slower than the host clock, with an unrelated phase. With these settings every header length from 1 to 4 can be combined with every payload length from 1 to 6, and each field is compared against check values the bench works out itself. The same settings make the busy-channel wait, a clear-channel drop in mid-frame, the fixed check vector and a forced starvation short enough to run back to back.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int HEC_BITS = 16;
    localparam int FCS_BITS = 32;
    localparam logic [15:0] HEC_POLY = 16'h1021;
    localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CLR,
        ST_HDR,
        ST_HEC,
        ST_PAY,
        ST_FCS
    } ser_state_t;

    // One serial step of the header check, data bit in send order.
    function automatic logic [15:0] hec_step(input logic [15:0] c, input logic b);
        hec_step = {c[14:0], 1'b0} ^ ((b ^ c[15]) ? HEC_POLY : 16'h0000);
    endfunction

    // One serial step of the reflected frame check.
    function automatic logic [31:0] fcs_step(input logic [31:0] c, input logic b);
        fcs_step = {1'b0, c[31:1]} ^ ((b ^ c[0]) ? FCS_POLY_REFL : 32'h0);
    endfunction

endpackage

// File: rtl/mtx_sync.sv
module mtx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mtx_host_port.sv
module mtx_host_port #(
    parameter int W           = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_word,
    input  logic         ack_tgl,
    output logic         in_ready,
    output logic         req_tgl,
    output logic [W-1:0] hold_word
);

    logic ack_s;

    mtx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    // Free when the returned acknowledge matches the last request.
    assign in_ready = (req_tgl == ack_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            hold_word <= '0;
        end else if (in_valid && in_ready) begin
            hold_word <= in_word;
            req_tgl   <= ~req_tgl;
        end
    end

    // R2: one byte outstanding at a time
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer
    import mtx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              req_tgl,
    input  logic [BYTE_W+1:0] hold_word,
    input  logic              chan_clear,
    output logic              ack_tgl,
    output logic              txd,
    output logic              tx_rdy,
    output logic              underrun
);

    localparam int CNT_W = $clog2(FCS_BITS);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] LD_BYTE = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LD_HEC  = CNT_W'(HEC_BITS - 1);
    localparam logic [CNT_W-1:0] LD_FCS  = CNT_W'(FCS_BITS - 1);

    ser_state_t state, nxt;

    logic req_s, clr_s;
    logic tfull, done, idle_like, active, take, starve;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              cur_hend, cur_last;
    logic [15:0]       c16;
    logic [31:0]       c32;
    logic [BYTE_W-1:0] new_byte;
    logic              new_hend, new_last;

    assign new_byte = hold_word[BYTE_W-1:0];
    assign new_hend = hold_word[BYTE_W];
    assign new_last = hold_word[BYTE_W+1];

    mtx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (tx_clk),
        .rst_n (tx_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    mtx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_clr_sync (
        .clk   (tx_clk),
        .rst_n (tx_rst_n),
        .d     (chan_clear),
        .q     (clr_s)
    );

    always_comb begin
        tfull     = req_s ^ ack_tgl;
        done      = (cnt == '0);
        idle_like = (state == ST_IDLE) || (state == ST_WAIT_CLR);
        active    = !idle_like;
    end

    // Next state and byte-boundary decisions.
    always_comb begin
        nxt    = state;
        take   = 1'b0;
        starve = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tfull) begin
                    if (clr_s) begin
                        nxt  = ST_HDR;
                        take = 1'b1;
                    end else begin
                        nxt = ST_WAIT_CLR;
                    end
                end
            end
            ST_WAIT_CLR: begin
                if (clr_s) begin
                    nxt  = ST_HDR;
                    take = 1'b1;
                end
            end
            ST_HDR: begin
                if (done) begin
                    if (cur_hend) begin
                        nxt = ST_HEC;
                    end else if (tfull) begin
                        take = 1'b1;
                    end else begin
                        nxt    = ST_IDLE;
                        starve = 1'b1;
                    end
                end
            end
            ST_HEC: begin
                if (done) begin
                    if (tfull) begin
                        nxt  = ST_PAY;
                        take = 1'b1;
                    end else begin
                        nxt    = ST_IDLE;
                        starve = 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (done) begin
                    if (cur_last) begin
                        nxt = ST_FCS;
                    end else if (tfull) begin
                        take = 1'b1;
                    end else begin
                        nxt    = ST_IDLE;
                        starve = 1'b1;
                    end
                end
            end
            ST_FCS: begin
                if (done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge tx_clk or negedge tx_rst_n) begin
        if (!tx_rst_n) state <= ST_IDLE;
        else           state <= nxt;
    end

    // Shifter, check registers and line outputs.
    always_ff @(posedge tx_clk or negedge tx_rst_n) begin
        if (!tx_rst_n) begin
            ack_tgl  <= 1'b0;
            txd      <= 1'b0;
            tx_rdy   <= 1'b0;
            underrun <= 1'b0;
            sh       <= '0;
            cnt      <= '0;
            cur_hend <= 1'b0;
            cur_last <= 1'b0;
            c16      <= '1;
            c32      <= '1;
        end else if (take) begin
            ack_tgl  <= ~ack_tgl;
            tx_rdy   <= 1'b1;
            txd      <= new_byte[0];
            sh       <= new_byte >> 1;
            cnt      <= LD_BYTE;
            cur_hend <= new_hend;
            cur_last <= new_last;
            if (idle_like) begin
                c16 <= hec_step(16'hFFFF, new_byte[0]);
                c32 <= '1;
            end else if (state == ST_HDR) begin
                c16 <= hec_step(c16, new_byte[0]);
            end else begin
                c32 <= fcs_step(c32, new_byte[0]);
            end
        end else if (active && !done) begin
            cnt <= cnt - CNT_ONE;
            unique case (state)
                ST_HDR: begin
                    txd <= sh[0];
                    sh  <= sh >> 1;
                    c16 <= hec_step(c16, sh[0]);
                end
                ST_PAY: begin
                    txd <= sh[0];
                    sh  <= sh >> 1;
                    c32 <= fcs_step(c32, sh[0]);
                end
                ST_HEC: begin
                    txd <= ~c16[15];
                    c16 <= {c16[14:0], 1'b0};
                end
                ST_FCS: begin
                    txd <= ~c32[0];
                    c32 <= {1'b0, c32[31:1]};
                end
                default: ;
            endcase
        end else if (state == ST_HDR && cur_hend) begin
            txd <= ~c16[15];
            c16 <= {c16[14:0], 1'b0};
            cnt <= LD_HEC;
        end else if (state == ST_PAY && cur_last) begin
            txd <= ~c32[0];
            c32 <= {1'b0, c32[31:1]};
            cnt <= LD_FCS;
        end else if (active) begin
            txd    <= 1'b0;
            tx_rdy <= 1'b0;
            if (starve) underrun <= 1'b1;
        end
    end

    // R3: deferred start keeps the line idle
    a_r3_wait_quiet: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        (state == ST_WAIT_CLR) |-> !tx_rdy);

    // R3: a frame starts only on a clear channel
    a_r3_start_on_clear: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $rose(tx_rdy) |-> $past(clr_s));

    // R5: line held low outside a frame
    a_r5_quiet_line: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        !tx_rdy |-> !txd);

    // R7: header check field never longer than 16 bits
    a_r7_hec_len: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        (state == ST_HEC) |-> (cnt < CNT_W'(HEC_BITS)));

    // R10: starvation flag is sticky
    a_r10_underrun_sticky: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        underrun |=> underrun);

endmodule

// File: rtl/modem_tx_serializer.sv
module modem_tx_serializer #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_hend,
    input  logic              in_last,
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              chan_clear,
    output logic              txd,
    output logic              tx_rdy,
    output logic              underrun
);

    localparam int WORD_W = BYTE_W + 2;

    logic              req_tgl, ack_tgl;
    logic [WORD_W-1:0] hold_word;

    mtx_host_port #(.W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
        .clk       (sys_clk),
        .rst_n     (sys_rst_n),
        .in_valid  (in_valid),
        .in_word   ({in_last, in_hend, in_data}),
        .ack_tgl   (ack_tgl),
        .in_ready  (in_ready),
        .req_tgl   (req_tgl),
        .hold_word (hold_word)
    );

    mtx_serializer #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_ser (
        .tx_clk     (tx_clk),
        .tx_rst_n   (tx_rst_n),
        .req_tgl    (req_tgl),
        .hold_word  (hold_word),
        .chan_clear (chan_clear),
        .ack_tgl    (ack_tgl),
        .txd        (txd),
        .tx_rdy     (tx_rdy),
        .underrun   (underrun)
    );

endmodule

// File: tb/modem_tx_serializer_bench.sv
module modem_tx_serializer_bench;

    logic sys_clk = 1'b0;
    logic tx_clk  = 1'b0;
    logic sys_rst_n, tx_rst_n;
    logic in_valid, in_hend, in_last, chan_clear;
    logic [7:0] in_data;
    logic in_ready, txd, tx_rdy, underrun;

    always #5 sys_clk = ~sys_clk;
    initial begin
        #3;
        forever #20 tx_clk = ~tx_clk;
    end

    modem_tx_serializer u_modem_tx_serializer (
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_hend    (in_hend),
        .in_last    (in_last),
        .tx_clk     (tx_clk),
        .tx_rst_n   (tx_rst_n),
        .chan_clear (chan_clear),
        .txd        (txd),
        .tx_rdy     (tx_rdy),
        .underrun   (underrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] hb [8];
    logic [7:0] pb [16];
    int nh, np;
    bit hdr_last_flag;
    logic cap [8192];
    int nb = 0;

    always @(negedge tx_clk) begin
        if (tx_rdy && nb < 8192) begin
            cap[nb] = txd;
            nb++;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input logic he, input logic la);
        @(negedge sys_clk);
        while (!in_ready) @(negedge sys_clk);
        in_valid = 1'b1;
        in_data  = b;
        in_hend  = he;
        in_last  = la;
        @(negedge sys_clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame();
        for (int i = 0; i < nh; i++) push_byte(hb[i], i == nh - 1, hdr_last_flag);
        for (int j = 0; j < np; j++) push_byte(pb[j], 1'b0, j == np - 1);
    endtask

    function automatic logic [15:0] hec_exp();
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < nh; i++)
            for (int k = 0; k < 8; k++)
                c = {c[14:0], 1'b0} ^ ((hb[i][k] ^ c[15]) ? 16'h1021 : 16'h0);
        return ~c;
    endfunction

    function automatic logic [31:0] fcs_exp();
        logic [31:0] c = 32'hFFFFFFFF;
        for (int j = 0; j < np; j++)
            for (int k = 0; k < 8; k++)
                c = {1'b0, c[31:1]} ^ ((pb[j][k] ^ c[0]) ? 32'hEDB88320 : 32'h0);
        return ~c;
    endfunction

    task automatic verify(input int base, input bit drop, output logic [31:0] fcs_got);
        int off;
        logic [7:0]  v;
        logic [15:0] h;
        logic [31:0] f;
        // R5: bit count of the frame
        check(drop ? "R4" : "R5", "frame bit count", 32'(nb - base), 32'(8 * (nh + np) + 48));
        off = base;
        for (int i = 0; i < nh; i++) begin
            for (int k = 0; k < 8; k++) v[k] = cap[off + k];
            check("R6", "header byte", {24'h0, v}, {24'h0, hb[i]});
            off += 8;
        end
        h = '0;
        for (int k = 0; k < 16; k++) h = {h[14:0], cap[off + k]};
        check("R7", "header check", {16'h0, h}, {16'h0, hec_exp()});
        off += 16;
        for (int j = 0; j < np; j++) begin
            for (int k = 0; k < 8; k++) v[k] = cap[off + k];
            check("R8", "payload byte", {24'h0, v}, {24'h0, pb[j]});
            off += 8;
        end
        for (int k = 0; k < 32; k++) f[k] = cap[off + k];
        check("R9", "frame check", f, fcs_exp());
        fcs_got = f;
    endtask

    task automatic run_frame(input bit drop, output logic [31:0] fcs_got);
        int base;
        base = nb;
        fork
            send_frame();
            begin
                if (drop) begin
                    wait (tx_rdy);
                    @(negedge tx_clk);
                    chan_clear = 1'b0;   // R4: late busy indication
                end
            end
        join
        wait (!tx_rdy);
        repeat (4) @(negedge tx_clk);
        chan_clear = 1'b1;
        verify(base, drop, fcs_got);
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] fg;
        int base;
        sys_rst_n = 1'b0;
        tx_rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        in_hend = 1'b0;
        in_last = 1'b0;
        chan_clear = 1'b1;
        hdr_last_flag = 1'b0;
        repeat (3) @(negedge tx_clk);
        sys_rst_n = 1'b1;
        tx_rst_n = 1'b1;
        @(negedge sys_clk);
        check("R1", "tx_rdy", {31'h0, tx_rdy}, 32'h0);
        check("R1", "txd", {31'h0, txd}, 32'h0);
        check("R1", "in_ready", {31'h0, in_ready}, 32'h1);
        check("R1", "underrun", {31'h0, underrun}, 32'h0);

        // Sweep of header and payload lengths.
        for (int h = 1; h <= 4; h++) begin
            for (int p = 1; p <= 6; p++) begin
                nh = h;
                np = p;
                hdr_last_flag = ((h + p) % 2) == 1;  // R8: ignored in header
                for (int i = 0; i < h; i++) hb[i] = 8'(h * 53 + i * 29 + p * 7);
                for (int j = 0; j < p; j++) pb[j] = 8'((p * 91 + j * 17 + h * 13) ^ (j << 3));
                run_frame(((h + p) % 3) == 0, fg);
            end
        end
        hdr_last_flag = 1'b0;

        // R9: fixed vector, payload "123456789".
        nh = 4;
        np = 9;
        for (int i = 0; i < 4; i++) hb[i] = 8'(8'hA0 + i);
        for (int j = 0; j < 9; j++) pb[j] = 8'(8'h31 + j);
        run_frame(1'b0, fg);
        check("R9", "fixed vector frame check", fg, 32'hCBF43926);

        // R3 and R2: deferred start while the channel is busy.
        nh = 2;
        np = 3;
        for (int i = 0; i < 2; i++) hb[i] = 8'(8'h5C + i * 3);
        for (int j = 0; j < 3; j++) pb[j] = 8'(8'hC3 - j * 5);
        chan_clear = 1'b0;
        base = nb;
        fork
            send_frame();
            begin
                repeat (40) @(negedge tx_clk);
                check("R3", "tx_rdy while busy", {31'h0, tx_rdy}, 32'h0);
                check("R2", "in_ready with byte pending", {31'h0, in_ready}, 32'h0);
                chan_clear = 1'b1;
            end
        join
        wait (!tx_rdy);
        repeat (4) @(negedge tx_clk);
        verify(base, 1'b0, fg);
        check("R10", "no spurious underrun", {31'h0, underrun}, 32'h0);

        // R10: starvation after one header byte.
        base = nb;
        push_byte(8'h96, 1'b0, 1'b0);
        wait (tx_rdy);
        wait (!tx_rdy);
        repeat (2) @(negedge tx_clk);
        check("R10", "bits before starvation", 32'(nb - base), 32'd8);
        for (int k = 0; k < 8; k++) fg[k] = cap[base + k];
        check("R10", "starved byte", {24'h0, fg[7:0]}, 32'h96);
        check("R10", "underrun set", {31'h0, underrun}, 32'h1);
        repeat (20) @(negedge tx_clk);
        check("R10", "underrun held", {31'h0, underrun}, 32'h1);
        check("R10", "line idle after starvation", {31'h0, tx_rdy}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule